// File: doc/BRIEF.md
# Linked-Descriptor Memory-to-Stream DMA Channel

This block moves bytes from memory onto a byte stream under the control of a chain of data descriptors held in memory. Software builds the chain, gives the channel the address of its first descriptor and pulses `start`. The channel fetches each descriptor and streams the bytes of its buffer, from the buffer pointer up to but not including the end pointer. It then writes the descriptor back to memory and raises an interrupt if the descriptor asks for one. After that it follows the next pointer, or, if the descriptor marks the end of the list, it parks.

A parked channel can be resumed without a fresh start. Software clears the end-of-list flag in the last descriptor's memory image, sets up a new tail and pulses `cont`. The channel re-reads the descriptor it parked on. If the flag is now clear, it follows the next pointer and carries on. If the flag is still set, it stays parked. Memory is reached through a single request/acknowledge port with word-wide data.

Top module: `dmaout_chan`

## Requirements
- R1: After reset the channel is idle: `mem_req`, `st_valid`, `busy`, `at_eol` and `irq` are all low.
- R2: A descriptor is four DW-wide words at a stride of DW/8 bytes, holding in order: next pointer, buffer pointer, flag word, end pointer. The channel reads all four before it moves any data. Flag bit 0 is end-of-list, bit 3 marks end-of-packet and bit 4 requests an interrupt.
- R3: The bytes at addresses buffer .. end-1 appear on `st_data` in ascending address order. Byte address a sits in lane a mod (DW/8) of its aligned word (little-endian).
- R4: A descriptor whose buffer pointer equals its end pointer produces no stream beat, yet it still completes (write-back, interrupt, chaining).
- R5: `st_last` is high on the final byte of a descriptor exactly when that descriptor's end-of-packet flag is set; it is low on every other beat.
- R6: Completing a descriptor whose interrupt flag is set sets the raw interrupt. `irq` is the raw interrupt gated by `intr_mask`, and an `intr_ack` pulse clears it.
- R7: After a descriptor's last byte the channel writes its four words back, unchanged, to the descriptor's own address.
- R8: A completed descriptor with end-of-list set parks the channel: `at_eol` rises and no further byte is sent. Without that flag, the channel loads the descriptor at the next pointer.
- R9: A `cont` pulse while parked, with `cfg_en` high and `cfg_stop` low, re-reads the parked descriptor's four words. If its end-of-list flag is now clear, the channel drops `at_eol` and proceeds to the next descriptor. Otherwise it stays parked.
- R10: A `cont` pulse while `cfg_en` is low or `cfg_stop` is high is ignored: no memory access occurs and `at_eol` stays high.
- R11: A `start` pulse while idle or parked clears `at_eol` on the next clock and begins loading the descriptor at `start_addr`.
- R12: A memory request keeps its address, direction and write data until acknowledged. A stream beat keeps its data and last marker until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Channel enable, qualifies continue |
| cfg_stop | input | 1 | Stop request, blocks continue |
| start | input | 1 | Pulse: begin a new chain |
| start_addr | input | AW | Address of the first descriptor |
| cont | input | 1 | Pulse: resume a parked chain |
| intr_mask | input | 1 | Interrupt enable |
| intr_ack | input | 1 | Pulse: clear the raw interrupt |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address (word aligned) |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | DW | Read data |
| st_valid | output | 1 | Stream byte valid |
| st_data | output | 8 | Stream byte |
| st_last | output | 1 | Final byte of a packet |
| st_ready | input | 1 | Client accepts the byte |
| busy | output | 1 | Channel not idle |
| at_eol | output | 1 | Parked at end of list |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that the memory answers each request with exactly one `mem_ack` cycle, and that it never acknowledges a cycle in which no request is pending. They also assume that `start` and `cont` are single-cycle pulses. The bench's memory model raises the acknowledge only when it sees a request, and only for one cycle. The control pulses are driven by tasks that hold them for exactly one clock. The client's `st_ready` follows a pseudo-random pattern, which exercises the stalls the hold properties cover.

// File: rtl/dmaout_pkg.sv
package dmaout_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_LOAD,
      S_FETCH,
      S_SEND,
      S_WBACK,
      S_HALT
   } chan_state_t;

   localparam int FLAG_EOL  = 0;
   localparam int FLAG_EOP  = 3;
   localparam int FLAG_INTR = 4;
endpackage

// File: rtl/dmaout_lane.sv
module dmaout_lane #(
   parameter int DW = 32,
   localparam int BYTES = DW / 8,
   localparam int OFF = $clog2(BYTES)
) (
   input  logic [DW-1:0]  word_i,
   input  logic [OFF-1:0] sel_i,
   output logic [7:0]     byte_o
);
   logic [7:0] lanes [BYTES];

   generate
      for (genvar g = 0; g < BYTES; g++) begin : g_lane
         assign lanes[g] = word_i[8*g +: 8];
      end
   endgenerate

   assign byte_o = lanes[sel_i];
endmodule

// File: rtl/dmaout_irq.sv
module dmaout_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic ack_i,
   input  logic mask_i,
   output logic irq_o
);
   logic raw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     raw_q <= 1'b0;
      else if (set_i) raw_q <= 1'b1;
      else if (ack_i) raw_q <= 1'b0;
   end

   assign irq_o = raw_q & mask_i;

   // R6: the raw interrupt only rises after a completion asked for it
   a_r6_rise_from_set: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q) |-> $past(set_i));
   // R6: acknowledge clears the raw interrupt
   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !set_i) |=> !raw_q);
endmodule

// File: rtl/dmaout_chan.sv
module dmaout_chan
   import dmaout_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   localparam int BYTES = DW / 8,
   localparam int OFF = $clog2(BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_en,
   input  logic          cfg_stop,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   input  logic          cont,
   input  logic          intr_mask,
   input  logic          intr_ack,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output logic          st_valid,
   output logic [7:0]    st_data,
   output logic          st_last,
   input  logic          st_ready,
   output logic          busy,
   output logic          at_eol,
   output logic          irq
);
   generate
      if (DW % 8 != 0 || DW < 16 || (1 << OFF) != BYTES)
         $error("DW must be a power-of-two multiple of 8, at least 16");
      if (AW > DW)
         $error("AW must fit in one descriptor word");
   endgenerate

   chan_state_t   state;
   logic [AW-1:0] desc_addr, nxt, bufp, aft, cur;
   logic [DW-1:0] flags, word_q;
   logic [1:0]    idx;
   logic          reload, eol_q;

   logic [AW-1:0] cur_inc;
   logic          beat, last_byte, go_wback, intr_set;

   assign cur_inc   = cur + AW'(1);
   assign beat      = st_valid && st_ready;
   assign last_byte = (cur_inc == aft);
   assign go_wback  = (state == S_SEND && beat && last_byte) ||
                      (state == S_LOAD && mem_ack && idx == 2'd3 && !reload &&
                       bufp == mem_rdata[AW-1:0]);
   assign intr_set  = go_wback && flags[FLAG_INTR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         desc_addr <= '0;
         nxt       <= '0;
         bufp      <= '0;
         aft       <= '0;
         cur       <= '0;
         flags     <= '0;
         word_q    <= '0;
         idx       <= '0;
         reload    <= 1'b0;
         eol_q     <= 1'b0;
      end else begin
         unique case (state)
            S_IDLE, S_HALT: begin
               if (start) begin
                  desc_addr <= start_addr;
                  eol_q     <= 1'b0;
                  reload    <= 1'b0;
                  idx       <= '0;
                  state     <= S_LOAD;
               end else if (state == S_HALT && cont && cfg_en && !cfg_stop) begin
                  reload <= 1'b1;
                  idx    <= '0;
                  state  <= S_LOAD;
               end
            end
            S_LOAD: if (mem_ack) begin
               idx <= idx + 2'd1;
               unique case (idx)
                  2'd0: nxt   <= mem_rdata[AW-1:0];
                  2'd1: bufp  <= mem_rdata[AW-1:0];
                  2'd2: flags <= mem_rdata;
                  default: aft <= mem_rdata[AW-1:0];
               endcase
               if (idx == 2'd3) begin
                  if (reload) begin
                     if (!flags[FLAG_EOL]) begin
                        desc_addr <= nxt;
                        eol_q     <= 1'b0;
                        reload    <= 1'b0;
                     end else begin
                        state <= S_HALT;
                     end
                  end else begin
                     cur   <= bufp;
                     state <= go_wback ? S_WBACK : S_FETCH;
                  end
               end
            end
            S_FETCH: if (mem_ack) begin
               word_q <= mem_rdata;
               state  <= S_SEND;
            end
            S_SEND: if (beat) begin
               cur <= cur_inc;
               if (last_byte)                 state <= S_WBACK;
               else if (cur_inc[OFF-1:0] == '0) state <= S_FETCH;
            end
            S_WBACK: if (mem_ack) begin
               idx <= idx + 2'd1;
               if (idx == 2'd3) begin
                  if (flags[FLAG_EOL]) begin
                     eol_q <= 1'b1;
                     state <= S_HALT;
                  end else begin
                     desc_addr <= nxt;
                     state     <= S_LOAD;
                  end
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = (state == S_LOAD) || (state == S_FETCH) || (state == S_WBACK);
      mem_we    = (state == S_WBACK);
      mem_addr  = desc_addr + (AW'(idx) << OFF);
      if (state == S_FETCH) mem_addr = {cur[AW-1:OFF], {OFF{1'b0}}};
      unique case (idx)
         2'd0:    mem_wdata = DW'(nxt);
         2'd1:    mem_wdata = DW'(bufp);
         2'd2:    mem_wdata = flags;
         default: mem_wdata = DW'(aft);
      endcase
   end

   dmaout_lane #(.DW(DW)) i_lane (
      .word_i (word_q),
      .sel_i  (cur[OFF-1:0]),
      .byte_o (st_data)
   );

   dmaout_irq i_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (intr_set),
      .ack_i  (intr_ack),
      .mask_i (intr_mask),
      .irq_o  (irq)
   );

   assign st_valid = (state == S_SEND);
   assign st_last  = st_valid && last_byte && flags[FLAG_EOP];
   assign busy     = (state != S_IDLE);
   assign at_eol   = eol_q;

   // R12: memory request held until acknowledged
   a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));
   // R12: stream beat held until accepted
   a_r12_st_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_last)));
   // R8: a parked channel sends nothing
   a_r8_quiet_at_eol: assert property (@(posedge clk) disable iff (!rst_n)
      at_eol |-> !st_valid);
   // R10: a blocked continue leaves the memory port quiet
   a_r10_blocked_cont: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_HALT && !start && cont && (!cfg_en || cfg_stop)) |=> !mem_req);
   // R11: start from idle or parked clears the end-of-list status
   a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == S_IDLE || state == S_HALT) && start) |=> !at_eol);
endmodule

// File: tb/test_dmaout_chan.sv
module test_dmaout_chan;
   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_en = 1'b0, cfg_stop = 1'b0;
   logic          start = 1'b0, cont = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic          intr_mask = 1'b0, intr_ack = 1'b0;
   logic          mem_req, mem_we, mem_ack = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic          st_valid, st_last, st_ready = 1'b0;
   logic [7:0]    st_data;
   logic          busy, at_eol, irq;

   always #2.5 clk = ~clk;

   dmaout_chan #(.AW(AW), .DW(DW)) i_dmaout_chan (.*);

   logic [31:0] mem [256];
   assign mem_rdata = mem[mem_addr[9:2]];

   int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0;
   logic [8:0] exp_q [$];
   logic [15:0] lfsr = 16'hACE1;
   bit ready_always = 1'b0;

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 7 + 3) ^ (a >> 3));
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // memory model and client ready, driven just after each edge
   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      st_ready = ready_always | lfsr[0] | lfsr[3];
      if (mem_req && !mem_ack) begin
         mem_ack = 1'b1;
         if (mem_we) begin
            n_wr++;
            // R7: write-back returns the descriptor unchanged
            chk(mem_wdata == mem[mem_addr[9:2]], "R7", "write-back word",
                mem_wdata, mem[mem_addr[9:2]]);
            mem[mem_addr[9:2]] = mem_wdata;
         end else n_rd++;
      end else mem_ack = 1'b0;
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && st_valid && st_ready) begin
         if (exp_q.size() == 0)
            chk(1'b0, "R3", "unexpected beat", {st_last, st_data}, 0);
         else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk(st_data == e[7:0], "R3", "byte", st_data, e[7:0]);
            chk(st_last == e[8], "R5", "last marker", st_last, e[8]);
         end
      end
   end

   task automatic expect_range(input int lo, input int hi, input bit eop);
      for (int a = lo; a < hi; a++) exp_q.push_back({eop && (a == hi - 1), pat(a)});
   endtask

   task automatic put_desc(input int at, input int nx, input int b, input int fl, input int af);
      mem[at >> 2] = nx; mem[(at >> 2) + 1] = b;
      mem[(at >> 2) + 2] = fl; mem[(at >> 2) + 3] = af;
   endtask

   task automatic pulse_start(input int a);
      @(negedge clk); start_addr = a; start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic pulse_cont();
      @(negedge clk); cont = 1'b1;
      @(negedge clk); cont = 1'b0;
   endtask

   task automatic run_to_halt(input string req);
      int t = 0;
      while (!at_eol && t < 20000) begin @(negedge clk); t++; end
      chk(at_eol, req, "watchdog waiting for end of list", at_eol, 1);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, req, "bytes left unsent", exp_q.size(), 0);
   endtask

   initial begin
      for (int w = 0; w < 256; w++)
         mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
      // flag bits: eol=bit0, eop=bit3, intr=bit4
      put_desc('h100, 'h140, 'h201, 'h18, 'h20A);
      put_desc('h140, 'h180, 'h300, 'h00, 'h300);
      put_desc('h180, 'h1C0, 'h305, 'h01, 'h308);
      put_desc('h1C0, 'h000, 'h310, 'h09, 'h314);

      repeat (3) @(negedge clk);
      chk(!mem_req && !st_valid, "R1", "port idle in reset", {mem_req, st_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy, "R1", "busy after reset", busy, 0);
      chk(!at_eol, "R1", "at_eol after reset", at_eol, 0);
      chk(!irq, "R1", "irq after reset", irq, 0);

      // chain D0 (intr, eop, unaligned) -> D1 empty (R4) -> D2 eol
      cfg_en = 1'b1;
      expect_range('h201, 'h20A, 1'b1);
      expect_range('h305, 'h308, 1'b0);
      pulse_start('h100);
      run_to_halt("R8");
      chk(n_rd == 16, "R2", "descriptor and data reads", n_rd, 16);
      chk(n_wr == 12, "R4", "write-backs incl. empty descriptor", n_wr, 12);
      chk(!irq, "R6", "masked irq", irq, 0);
      intr_mask = 1'b1; @(negedge clk);
      chk(irq, "R6", "irq after unmask", irq, 1);
      @(negedge clk); intr_ack = 1'b1; @(negedge clk); intr_ack = 1'b0; @(negedge clk);
      chk(!irq, "R6", "irq after ack", irq, 0);

      // R10: blocked continues
      n_rd = 0; n_wr = 0;
      cfg_en = 1'b0; pulse_cont(); repeat (10) @(negedge clk);
      chk(n_rd + n_wr == 0, "R10", "access with enable low", n_rd + n_wr, 0);
      chk(at_eol, "R10", "at_eol with enable low", at_eol, 1);
      cfg_en = 1'b1; cfg_stop = 1'b1; pulse_cont(); repeat (10) @(negedge clk);
      chk(n_rd + n_wr == 0, "R10", "access with stop high", n_rd + n_wr, 0);
      chk(at_eol, "R10", "at_eol with stop high", at_eol, 1);
      cfg_stop = 1'b0;

      // R9: continue with eol still set re-reads and stays parked
      pulse_cont(); repeat (20) @(negedge clk);
      chk(n_rd == 4, "R9", "re-read count", n_rd, 4);
      chk(at_eol && n_wr == 0, "R9", "still parked", {at_eol, 8'(n_wr)}, 'h100);

      // R9: clear eol in D2, continue runs D3 (eop, eol)
      mem['h188 >> 2] = 0;
      n_rd = 0;
      expect_range('h310, 'h314, 1'b1);
      pulse_cont();
      repeat (3) @(negedge clk);
      while (at_eol && n_rd < 4) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(!at_eol, "R9", "at_eol dropped on resume", at_eol, 0);
      run_to_halt("R9");
      chk(n_rd == 9 && n_wr == 4, "R9", "resume traffic", {8'(n_rd), 8'(n_wr)}, 'h0904);

      // R11: restart at D1 with ready always high
      ready_always = 1'b1;
      expect_range('h305, 'h308, 1'b0);
      expect_range('h310, 'h314, 1'b1);
      pulse_start('h140);
      chk(!at_eol && busy, "R11", "status after start", {at_eol, busy}, 1);
      run_to_halt("R11");
      chk(!irq, "R6", "no irq without intr flag", irq, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R8", "global watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule